// File: doc/BRIEF.md
# Memory Start-Up Command Sequencer

This block produces the fixed series of commands that a memory controller must place on a synchronous DRAM after reset and before any normal access. It first waits a stabilisation interval, which is derived from the clock frequency. It then issues one precharge and, after a recovery delay, eight auto-refresh commands spaced by a refresh-cycle delay. It finishes with one mode-register load that carries a configuration word on the address bus.

The precharge-recovery and refresh-cycle delays arrive as input ports counted in clock cycles. They must stay stable while the sequence runs. The configuration word is assembled from three fields: read latency, output mode and write-mask behaviour. The load cycle and the three clocks that follow it form a lockout. When the lockout ends, the block raises `ready_o` and holds it high. From then on only stand-by commands leave the block, and the main controller takes over.

Every output is registered. Cycle n below means the outputs as they stand after the n-th rising clock edge at which `rst` is sampled low. PAUSE = `CLK_MHZ*PAUSE_US`. TP and TC are `trp_i` and `trc_i`, except that a value of 0 is read as 1.

Top module: `mem_init_seq`

## Requirements
- R1: While `rst` is high, and in cycle 1, `cmd_o` is stand-by (code 0), `addr_o` is 0 and `ready_o` is 0.
- R2: A precharge (code 1) appears on `cmd_o` in cycle PAUSE, exactly once per sequence.
- R3: Auto-refresh (code 2) appears in cycles PAUSE+TP+i*TC for i = 0..7, eight times and no more.
- R4: The mode-register load (code 3) appears exactly once, in cycle PAUSE+TP+8*TC.
- R5: During the load cycle, `addr_o[2:0]` = `lat_i`, `addr_o[4:3]` = output mode (0 transparent, 1 latched, 2 registered), `addr_o[5]` = `wmask_i` (1 set-all, 0 no change), and the upper bits are 0.
- R6: An output-mode request of 3 is sent as 0 (transparent).
- R7: In every cycle that is not one of the above, `cmd_o` is stand-by (0) and `addr_o` is 0.
- R8: `ready_o` first goes high in the cycle four after the load cycle and stays high with stand-by commands until reset.
- R9: A `trp_i` or `trc_i` value of 0 behaves exactly like a value of 1.
- R10: A reset asserted at any point, including mid-sequence, drops `ready_o`, and the sequence restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trp_i | input | TW | Precharge-recovery delay in cycles |
| trc_i | input | TW | Refresh-cycle delay in cycles |
| lat_i | input | 3 | Read latency field |
| omode_i | input | 2 | Output mode request |
| wmask_i | input | 1 | Write-mask mode |
| cmd_o | output | 2 | Command code: 0 stand-by, 1 precharge, 2 auto-refresh, 3 mode load |
| addr_o | output | AW | Address bus, carries the mode word on load |
| ready_o | output | 1 | Start-up complete |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of the sequence. It matters most when that reset falls inside the refresh train or the lockout, where both the delay timer and the refresh counter hold partial state. To reach it, the stimulus aborts runs at random cycles, re-asserts reset, and then requires the next complete run to match the expected timeline from its first cycle. Zero delays and the illegal output mode are driven as directed corner cases, alongside random delay and field values.

// File: rtl/mis_pkg.sv
package mis_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_SET = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_REFW,
        ST_LOCK,
        ST_DONE
    } state_e;

    localparam int LOCK_CYC = 4;
endpackage

// File: rtl/mis_wait_timer.sv
module mis_wait_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mis_ref_counter.sv
module mis_ref_counter #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic zero
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(N);
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CW'(N);
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mem_init_seq.sv
module mem_init_seq
    import mis_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int PAUSE_US = 500,
    parameter int TW       = 8,
    parameter int AW       = 12,
    parameter int N_REF    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] trp_i,
    input  logic [TW-1:0] trc_i,
    input  logic [2:0]    lat_i,
    input  logic [1:0]    omode_i,
    input  logic          wmask_i,
    output logic [1:0]    cmd_o,
    output logic [AW-1:0] addr_o,
    output logic          ready_o
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int PW        = $clog2(PAUSE_CYC + 1);
    localparam int TMW       = (PW > TW) ? PW : TW;

    typedef struct packed {
        state_e        st;
        cmd_e          cmd;
        logic [AW-1:0] addr;
        logic          ready;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic           tm_load, tm_zero;
    logic [TMW-1:0] tm_val;
    logic           rc_load, rc_dec, rc_zero;
    logic [TMW-1:0] trp_ld, trc_ld;
    logic [1:0]     om_fix;
    logic [AW-1:0]  mode_word;

    // a delay of 0 is taken as 1; the timer holds delay-1
    assign trp_ld    = (trp_i == '0) ? '0 : TMW'(trp_i) - 1'b1;
    assign trc_ld    = (trc_i == '0) ? '0 : TMW'(trc_i) - 1'b1;
    assign om_fix    = (omode_i == 2'b11) ? 2'b00 : omode_i;
    assign mode_word = AW'({wmask_i, om_fix, lat_i});

    mis_wait_timer #(
        .W       (TMW),
        .RST_VAL (PAUSE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    mis_ref_counter #(
        .N (N_REF)
    ) u_refcnt (
        .clk  (clk),
        .rst  (rst),
        .load (rc_load),
        .dec  (rc_dec),
        .zero (rc_zero)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.cmd  = CMD_NOP;
        nxt_d.addr = '0;
        tm_load    = 1'b0;
        tm_val     = '0;
        rc_load    = 1'b0;
        rc_dec     = 1'b0;
        case (cur_q.st)
            ST_PAUSE: begin
                if (tm_zero) begin
                    nxt_d.cmd = CMD_PRE;
                    nxt_d.st  = ST_REFW;
                    tm_load   = 1'b1;
                    tm_val    = trp_ld;
                    rc_load   = 1'b1;
                end
            end
            ST_REFW: begin
                if (tm_zero) begin
                    tm_load = 1'b1;
                    if (rc_zero) begin
                        nxt_d.cmd  = CMD_SET;
                        nxt_d.addr = mode_word;
                        nxt_d.st   = ST_LOCK;
                        tm_val     = TMW'(LOCK_CYC - 1);
                    end else begin
                        nxt_d.cmd = CMD_REF;
                        rc_dec    = 1'b1;
                        tm_val    = trc_ld;
                    end
                end
            end
            ST_LOCK: begin
                if (tm_zero) begin
                    nxt_d.ready = 1'b1;
                    nxt_d.st    = ST_DONE;
                end
            end
            default: begin
                nxt_d.st = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st    <= ST_PAUSE;
            cur_q.cmd   <= CMD_NOP;
            cur_q.addr  <= '0;
            cur_q.ready <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cmd_o   = cur_q.cmd;
    assign addr_o  = cur_q.addr;
    assign ready_o = cur_q.ready;
endmodule

// File: rtl/mis_chk.sv
module mis_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd,
    input logic [AW-1:0] addr,
    input logic          ready
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (cmd == 2'd0 && addr == '0 && !ready));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cmd == 2'd0));

    // R8
    ready_after_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(cmd, 4) == 2'd3));

    // R7
    addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != 2'd3) |-> (addr == '0));

    // R6
    omode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd3) |-> (addr[4:3] != 2'b11));

    // R4
    set_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd3) |=> (cmd == 2'd0));
endmodule

bind mem_init_seq mis_chk #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd_o),
    .addr  (addr_o),
    .ready (ready_o)
);

// File: tb/tb_mem_init_seq.sv
module tb_mem_init_seq;
    localparam int CLK_MHZ  = 1;
    localparam int PAUSE_US = 20;
    localparam int P        = CLK_MHZ * PAUSE_US;
    localparam int TW       = 8;
    localparam int AW       = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] trp = '0;
    logic [TW-1:0] trc = '0;
    logic [2:0]    lat = '0;
    logic [1:0]    omode = '0;
    logic          wmask = 1'b0;
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic          ready;

    int errs = 0;
    int checks = 0;
    bit finished = 0;
    bit after_abort = 0;

    always #5 clk = ~clk;

    mem_init_seq #(
        .CLK_MHZ  (CLK_MHZ),
        .PAUSE_US (PAUSE_US),
        .TW       (TW),
        .AW       (AW),
        .N_REF    (8)
    ) dut (
        .clk     (clk),
        .rst     (rst),
        .trp_i   (trp),
        .trc_i   (trc),
        .lat_i   (lat),
        .omode_i (omode),
        .wmask_i (wmask),
        .cmd_o   (cmd),
        .addr_o  (addr),
        .ready_o (ready)
    );

    function automatic int eff(int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic int exp_cmd(int n, int tp, int tc);
        int te = eff(tp);
        int ce = eff(tc);
        if (n == P) return 1;
        for (int i = 0; i < 8; i++)
            if (n == P + te + i * ce) return 2;
        if (n == P + te + 8 * ce) return 3;
        return 0;
    endfunction

    function automatic int exp_addr(int n, int tp, int tc, int l, int om, int wm);
        if (exp_cmd(n, tp, tc) != 3) return 0;
        return (wm << 5) | (((om == 3) ? 0 : om) << 3) | l;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(int tp, int tc, int l, int om, int wm, int abort_n);
        int s;
        int last;
        @(negedge clk);
        rst = 1'b1;
        trp = TW'(tp); trc = TW'(tc);
        lat = 3'(l); omode = 2'(om); wmask = 1'(wm);
        repeat (2) @(negedge clk);
        // R1: outputs held quiet while reset is high
        chk("R1 cmd in reset", int'(cmd), 0);
        chk("R1 addr in reset", int'(addr), 0);
        chk("R1 ready in reset", int'(ready), 0);
        rst = 1'b0;
        s = P + eff(tp) + 8 * eff(tc);
        last = (abort_n > 0) ? abort_n : s + 6;
        for (int n = 1; n <= last; n++) begin
            int ec;
            string tg;
            @(negedge clk);
            ec = exp_cmd(n, tp, tc);
            if (after_abort) tg = "R10";
            else if (tp == 0 || tc == 0) tg = "R9";
            else if (n == 1) tg = "R1";
            else if (ec == 1) tg = "R2";
            else if (ec == 2) tg = "R3";
            else if (ec == 3) tg = "R4";
            else tg = "R7";
            chk({tg, " cmd"}, int'(cmd), ec);
            chk((ec == 3) ? ((om == 3) ? "R6 addr" : "R5 addr") : {tg, " addr"},
                int'(addr), exp_addr(n, tp, tc, l, om, wm));
            chk("R8 ready", int'(ready), (n >= s + 4) ? 1 : 0);
        end
        after_abort = (abort_n > 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        // directed corners
        run(1, 1, 5, 2, 1, 0);
        run(0, 0, 3, 1, 0, 0);          // R9
        run(3, 4, 7, 3, 1, 0);          // R6
        run(15, 15, 0, 0, 0, 0);
        run(2, 3, 1, 1, 1, P + 10);     // abort inside refresh train
        run(2, 3, 6, 2, 0, 0);          // R10
        run(4, 2, 2, 0, 1, P + 4 + 8 * 2 + 2); // abort inside lockout
        run(4, 2, 2, 1, 1, 0);          // R10
        // random stimulus
        for (int k = 0; k < 40; k++) begin
            int tp = $urandom_range(0, 12);
            int tc = $urandom_range(0, 12);
            int ab = ($urandom_range(0, 3) == 0) ? $urandom_range(1, P + 60) : 0;
            run(tp, tc, $urandom_range(0, 7), $urandom_range(0, 3),
                $urandom_range(0, 1), ab);
        end
        run(5, 5, 4, 2, 1, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule